// File: doc/BRIEF.md
# Self-Incrementing Column Burst Reader

This block drives the column side of a read from a DRAM row that is already open. A requester hands over one starting column with a single valid/ready handshake. The block then issues four consecutive column addresses on its own, one per cycle. The column register steps inside an aligned group of four, so the requester never supplies the later columns.

Each column travels through a chain of registered stages: issue, a tag pipeline that waits out the memory's fixed read latency, and a capture register. With the default memory latency of three cycles, the first word appears five cycles after the request and each later word one cycle after the one before it, which gives 5-1-1-1 timing. Every delivered word carries its beat index and a flag on the final beat.

A request may arrive at any time. One that arrives while a burst is still running drops whatever that burst has not yet delivered and starts the new burst with the normal timing.

Top module: `col_burst_reader`

## Requirements
- R1: `reqReady` is 1 in every cycle after reset. A request is accepted at every rising edge at which `reqValid` is 1.
- R2: After a request is accepted at edge a, `memColValid` is 1 after edges a+1, a+2, a+3 and a+4, with beat k (k = 0..3) issued after edge a+1+k. `memColValid` is 0 at all other times.
- R3: For the request accepted at edge a, word k appears with `wordValid` = 1 after edge a+MEM_LAT+2+k. With the default MEM_LAT = 3 this is a+5, a+6, a+7 and a+8. `wordValid` is 0 at all other times.
- R4: The column for beat k equals the starting column with bits [1:0] replaced by (start[1:0] + k) mod 4. Bits above bit 1 stay equal to the starting column.
- R5: `wordData` for beat k is the value on `memData` after edge (issue edge of that beat) + MEM_LAT.
- R6: `wordBeat` carries k (0..3) with each delivered word. `wordLast` is 1 exactly when beat 3 is delivered.
- R7: When a request is accepted at edge b, no column and no word of any earlier burst appears after edge b or later, including edge b itself. The new burst follows R2 and R3 counted from b.
- R8: A burst cut short before its beat 3 is delivered never raises `wordLast`.
- R9: While `rstN` is 0, `memColValid`, `wordValid` and `wordLast` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Start-column request valid |
| reqReady | output | 1 | Request ready, held at 1 |
| reqCol | input | COL_W | Starting column |
| memColValid | output | 1 | Column strobe toward the memory |
| memCol | output | COL_W | Column address toward the memory |
| memData | input | DATA_W | Read data, MEM_LAT cycles after the column |
| wordValid | output | 1 | Delivered word valid |
| wordData | output | DATA_W | Delivered word |
| wordBeat | output | 2 | Beat index of the delivered word |
| wordLast | output | 1 | Final beat of a completed burst |

## Verification
The embedded properties check the following on every cycle:
- consecutive column strobes keep the upper column bits and step the low two bits by one;
- a delivered word that is not the last is followed either by the next beat or by silence;
- the last flag appears only with beat 3;
- an accepted request clears the output on the following edge.

Only the directed scenarios can show the following:
- the absolute 5-1-1-1 spacing measured from acceptance;
- that the returned data belongs to the right column;
- exactly which beats of an interrupted burst survive when the interruption lands early, mid-delivery, on the final beat, or in a rapid chain of requests.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int BURST_LEN = 4;
  localparam int BEAT_W    = $clog2(BURST_LEN);

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic              load;   // take a new start column
    logic              issue;  // send the current column this cycle
    logic              flush;  // drop everything in flight
    logic [BEAT_W-1:0] beat;   // beat index of the issued column
    logic              last;   // issued column is the final beat
  } cbr_strobe_t;
endpackage

// File: rtl/cbr_ctrl.sv
module cbr_ctrl
  import cbr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output cbr_strobe_t strb
);
  logic              active;
  logic [BEAT_W-1:0] beatCnt;

  always_comb begin
    strb.load  = reqValid;
    strb.flush = reqValid;
    strb.issue = active && !reqValid;
    strb.beat  = beatCnt;
    strb.last  = (beatCnt == BEAT_W'(BURST_LEN - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      beatCnt <= '0;
    end else if (reqValid) begin
      active  <= 1'b1;
      beatCnt <= '0;
    end else if (active) begin
      if (beatCnt == BEAT_W'(BURST_LEN - 1)) active <= 1'b0;
      beatCnt <= beatCnt + 1'b1;
    end
  end

  // R7: an accepted request always restarts the beat sequence at zero
  a_r7_restart: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (active && beatCnt == '0));
endmodule

// File: rtl/cbr_datapath.sv
module cbr_datapath
  import cbr_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int DATA_W  = 16,
  parameter int MEM_LAT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  cbr_strobe_t       strb,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] memData,
  output logic              memColValid,
  output logic [COL_W-1:0]  memCol,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData,
  output logic [BEAT_W-1:0] wordBeat,
  output logic              wordLast
);
  localparam int TAG_N = MEM_LAT + 1;

  logic [COL_W-1:0]             colReg;
  logic [TAG_N-1:0]             tagV;
  logic [TAG_N-1:0]             tagLast;
  logic [TAG_N-1:0][BEAT_W-1:0] tagBeat;

  // issue stage and tag pipeline tracking the memory latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colReg  <= '0;
      memCol  <= '0;
      tagV    <= '0;
      tagLast <= '0;
      tagBeat <= '0;
    end else begin
      if (strb.load)
        colReg <= reqCol;
      else if (strb.issue)
        colReg <= {colReg[COL_W-1:BEAT_W], colReg[BEAT_W-1:0] + 1'b1};
      if (strb.issue) memCol <= colReg;
      tagV[0]    <= strb.issue;
      tagBeat[0] <= strb.beat;
      tagLast[0] <= strb.last;
      for (int j = 1; j < TAG_N; j++) begin
        tagV[j]    <= strb.flush ? 1'b0 : tagV[j-1];
        tagBeat[j] <= tagBeat[j-1];
        tagLast[j] <= tagLast[j-1];
      end
    end
  end

  assign memColValid = tagV[0];

  // capture stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordValid <= 1'b0;
      wordData  <= '0;
      wordBeat  <= '0;
      wordLast  <= 1'b0;
    end else begin
      wordValid <= !strb.flush && tagV[TAG_N-1];
      wordLast  <= !strb.flush && tagV[TAG_N-1] && tagLast[TAG_N-1];
      wordData  <= memData;
      wordBeat  <= tagBeat[TAG_N-1];
    end
  end

  // R4: back-to-back column strobes step inside the aligned group
  a_r4_col_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (memColValid && $past(memColValid)) |->
      (memCol[COL_W-1:BEAT_W] == $past(memCol[COL_W-1:BEAT_W]) &&
       memCol[BEAT_W-1:0] == $past(memCol[BEAT_W-1:0]) + 1'b1));

  // R6: last flag only on the final beat
  a_r6_last_beat: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordLast) |-> (wordBeat == BEAT_W'(BURST_LEN - 1)));

  // R3: a non-final word is followed by its successor or by nothing
  a_r3_beat_step: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordLast) |=> (!wordValid || wordBeat == $past(wordBeat) + 1'b1));

  // R7: an accepted request silences the output and the issue stage
  a_r7_flush_drop: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.flush) |-> (!wordValid && !memColValid));
endmodule

// File: rtl/col_burst_reader.sv
module col_burst_reader
  import cbr_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int DATA_W  = 16,
  parameter int MEM_LAT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [COL_W-1:0]  reqCol,
  output logic              memColValid,
  output logic [COL_W-1:0]  memCol,
  input  logic [DATA_W-1:0] memData,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData,
  output logic [1:0]        wordBeat,
  output logic              wordLast
);
  cbr_strobe_t strb;

  assign reqReady = 1'b1;

  cbr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strb     (strb)
  );

  cbr_datapath #(
    .COL_W   (COL_W),
    .DATA_W  (DATA_W),
    .MEM_LAT (MEM_LAT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqCol      (reqCol),
    .memData     (memData),
    .memColValid (memColValid),
    .memCol      (memCol),
    .wordValid   (wordValid),
    .wordData    (wordData),
    .wordBeat    (wordBeat),
    .wordLast    (wordLast)
  );
endmodule

// File: tb/sim_col_burst_reader.sv
`timescale 1ns/1ps
module sim_col_burst_reader;
  localparam int COL_W   = 8;
  localparam int DATA_W  = 16;
  localparam int MEM_LAT = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [COL_W-1:0]  reqCol = '0;
  logic              memColValid;
  logic [COL_W-1:0]  memCol;
  logic [DATA_W-1:0] memData;
  logic              wordValid;
  logic [DATA_W-1:0] wordData;
  logic [1:0]        wordBeat;
  logic              wordLast;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  int         sN;
  int         sAt  [3];
  logic [7:0] sCol [3];

  always #2.5 clk = ~clk;

  col_burst_reader #(.COL_W(COL_W), .DATA_W(DATA_W), .MEM_LAT(MEM_LAT)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCol(reqCol), .memColValid(memColValid), .memCol(memCol),
    .memData(memData), .wordValid(wordValid), .wordData(wordData),
    .wordBeat(wordBeat), .wordLast(wordLast)
  );

  function automatic logic [DATA_W-1:0] dataOf(input logic [COL_W-1:0] c);
    return DATA_W'({c, ~c}) ^ 16'h5A3C;
  endfunction

  // memory model: data for a column appears MEM_LAT cycles after its strobe
  logic [DATA_W-1:0] memPipe [MEM_LAT];
  always @(posedge clk) begin
    memPipe[0] <= memColValid ? dataOf(memCol) : 16'hDEAD;
    for (int i = 1; i < MEM_LAT; i++) memPipe[i] <= memPipe[i-1];
  end
  assign memData = memPipe[MEM_LAT-1];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 50000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int latestReq(input int m);
    int best = -1;
    for (int i = 0; i < sN; i++)
      if (sAt[i] <= m && (best < 0 || sAt[i] > sAt[best])) best = i;
    return best;
  endfunction

  function automatic logic [7:0] colOf(input logic [7:0] s, input int k);
    return {s[7:2], 2'(s[1:0] + k)};
  endfunction

  // compare outputs seen after edge m against the requirement model
  task automatic checkEdge(input int m, input string vTag, input string lTag, input string cTag);
    int r = latestReq(m);
    int ki = (r < 0) ? -10 : m - sAt[r] - 1;
    int kw = (r < 0) ? -10 : m - sAt[r] - (MEM_LAT + 2);
    bit expI = (ki >= 0 && ki <= 3);
    bit expW = (kw >= 0 && kw <= 3);
    chk(memColValid == expI, "R2", $sformatf("memColValid edge %0d", m), memColValid, expI);
    if (expI && memColValid)
      chk(memCol == colOf(sCol[r], ki), cTag, $sformatf("memCol edge %0d", m), memCol, colOf(sCol[r], ki));
    chk(wordValid == expW, vTag, $sformatf("wordValid edge %0d", m), wordValid, expW);
    if (expW && wordValid) begin
      chk(wordData == dataOf(colOf(sCol[r], kw)), "R5", $sformatf("wordData edge %0d", m),
          wordData, dataOf(colOf(sCol[r], kw)));
      chk(wordBeat == 2'(kw), "R6", $sformatf("wordBeat edge %0d", m), wordBeat, kw);
    end
    if (wordValid || expW)
      chk(wordLast == (expW && kw == 3), lTag, $sformatf("wordLast edge %0d", m), wordLast, (expW && kw == 3));
  endtask

  task automatic runScenario(input string vTag, input string lTag, input string cTag);
    int span = 0;
    for (int i = 0; i < sN; i++) if (sAt[i] > span) span = sAt[i];
    span += 12;
    for (int n = 1; n <= span + 1; n++) begin
      @(negedge clk);
      if (n > 1) checkEdge(n - 1, vTag, lTag, cTag);
      reqValid = 1'b0;
      for (int i = 0; i < sN; i++)
        if (sAt[i] == n) begin
          reqValid = 1'b1;
          reqCol   = sCol[i];
        end
      if (reqValid) chk(reqReady == 1'b1, "R1", "reqReady", reqReady, 1);
    end
    reqValid = 1'b0;
  endtask

  task automatic testReset;
    repeat (3) @(negedge clk);
    chk(memColValid == 0, "R9", "memColValid in reset", memColValid, 0);
    chk(wordValid == 0, "R9", "wordValid in reset", wordValid, 0);
    chk(wordLast == 0, "R9", "wordLast in reset", wordLast, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1, "R1", "reqReady after reset", reqReady, 1);
  endtask

  task automatic testSingleAligned; // R3 five-one-one-one spacing
    sN = 1; sAt[0] = 1; sCol[0] = 8'h10;
    runScenario("R3", "R6", "R2");
  endtask

  task automatic testWrap; // R4 low bits wrap 3E,3F,3C,3D
    sN = 1; sAt[0] = 1; sCol[0] = 8'h3E;
    runScenario("R3", "R6", "R4");
  endtask

  task automatic testEarlyCut; // R7 before any word arrives
    sN = 2; sAt[0] = 1; sCol[0] = 8'h21; sAt[1] = 3; sCol[1] = 8'h47;
    runScenario("R7", "R8", "R7");
  endtask

  task automatic testMidCut; // R7 after first word delivered
    sN = 2; sAt[0] = 1; sCol[0] = 8'h52; sAt[1] = 7; sCol[1] = 8'h9B;
    runScenario("R7", "R8", "R7");
  endtask

  task automatic testCutOnLast; // R8 request lands on the beat-3 edge
    sN = 2; sAt[0] = 1; sCol[0] = 8'hC1; sAt[1] = 9; sCol[1] = 8'h0C;
    runScenario("R7", "R8", "R7");
  endtask

  task automatic testBackToBack; // R3 two full bursts
    sN = 2; sAt[0] = 1; sCol[0] = 8'h77; sAt[1] = 10; sCol[1] = 8'hE2;
    runScenario("R3", "R6", "R4");
  endtask

  task automatic testChain; // R7 three requests on consecutive edges
    sN = 3; sAt[0] = 1; sCol[0] = 8'h05; sAt[1] = 2; sCol[1] = 8'hA9; sAt[2] = 3; sCol[2] = 8'hFF;
    runScenario("R7", "R8", "R4");
  endtask

  initial begin
    testReset();
    testSingleAligned();
    testWrap();
    testEarlyCut();
    testMidCut();
    testCutOnLast();
    testBackToBack();
    testChain();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule